// File: doc/BRIEF.md
# Quarter-Step Fractional Main Divider

This block divides a fast oscillator clock by a programmable average ratio of N + k/4. Every output period lasts exactly N or N+1 input clocks. A two-bit phase accumulator picks between the two, so that over any four consecutive periods the total is 4N + k clocks. The ratio is programmed as one 15-bit word, SFeff = 4N + k. The upper 13 bits carry N and the lower 2 bits carry k. The divided pulse feeds a phase comparator. A monitor pin can mirror that pulse for test.

The configuration word, its load strobe and the pump-busy indication are plain control pins. There is no data stream, so there is no valid/ready handshake and no back-pressure.

A word on `sf_word` is captured only when `sf_load` marks the end of a bus write. The captured value waits in a shadow register. It becomes active at the next period boundary at which `pump_busy` is low, so a retune never cuts into a charge-pump pulse. After reset the divider stays idle and emits no pulses until the first word has been loaded. Words below the legal minimum of 2048 are raised to 2048, and this is reported on `sf_clamped`.

Top module: `fnd_main_div`

## Requirements
- R1: After reset and before the first `sf_load`, `div_pulse` and `mon_out` stay low and `sf_clamped` is low.
- R2: The active word is split as N = bits 14..2 and k = bits 1..0. Every interval between consecutive `div_pulse` highs is either N or N+1 clocks.
- R3: With k = 0, every interval is exactly N clocks.
- R4: With k in 1..3, any four consecutive intervals sum to 4N + k clocks.
- R5: A change on `sf_word` without an `sf_load` strobe has no effect on the interval length.
- R6: While `pump_busy` is high, a loaded word is held pending and the old ratio continues. The new ratio takes effect at the first period boundary where `pump_busy` is low. The period that ends at that boundary still has the old length.
- R7: A loaded word below 2048 is replaced by 2048 (N = 512, k = 0) and sets `sf_clamped`. The next load of a legal word clears `sf_clamped`.
- R8: `mon_out` equals `div_pulse` while `test_en` is high and is low while `test_en` is low.
- R9: The largest word, 32767, yields intervals of 8191 and 8192 clocks that sum to 32767 over four periods.
- R10: `div_pulse` is high for exactly one clock per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| sf_word | input | 15 | Effective scale factor 4N + k |
| sf_load | input | 1 | One-cycle strobe: bus write of `sf_word` has completed |
| pump_busy | input | 1 | Charge pump is currently sourcing or sinking |
| test_en | input | 1 | Routes the divided pulse to `mon_out` |
| div_pulse | output | 1 | One-clock pulse at the end of each divided period |
| mon_out | output | 1 | Test monitor copy of `div_pulse` |
| sf_clamped | output | 1 | Last loaded word was below 2048 and was raised |

## Verification
The bench measures every pulse-to-pulse interval and checks each fractional setting against the four-period sum. A sequencer that mishandled the accumulator carry would drift from 4N + k even when every single interval looked plausible.

The retune tests hold `pump_busy` across several boundaries and then release it mid-period. A divider that applied the word too early, or that cut the period in progress short, would show a wrong-length interval right at the switch.

Further checks cover:
- a word changed without its strobe;
- a word below the minimum, which must clamp to 512-clock periods rather than wrap to a tiny ratio;
- the largest word, where an N+1 of 8192 overflows a counter that is one bit too narrow.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int INT_W  = 13;
  localparam int FRAC_W = 2;
  localparam int SF_W   = INT_W + FRAC_W;
  localparam int SF_MIN = 2048;
  localparam int CNT_W  = INT_W + 1;

  typedef logic [SF_W-1:0] sf_t;

  function automatic sf_t clamp_sf(input sf_t w);
    if (w < sf_t'(SF_MIN)) return sf_t'(SF_MIN);
    return w;
  endfunction
endpackage

// File: rtl/fnd_cfg_sync.sv
module fnd_cfg_sync
  import fnd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sf_t  sf_word,
  input  logic sf_load,
  input  logic pump_busy,
  input  logic wrap,
  output logic apply,
  output logic running,
  output sf_t  eff_word,
  output sf_t  act_word,
  output logic clamped
);
  sf_t  shadow_q;
  logic pending_q;

  assign apply    = pending_q && !pump_busy && (wrap || !running);
  assign eff_word = apply ? shadow_q : act_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      pending_q <= 1'b0;
      clamped   <= 1'b0;
    end else if (sf_load) begin
      shadow_q  <= clamp_sf(sf_word);
      pending_q <= 1'b1;
      clamped   <= (sf_word < sf_t'(SF_MIN));
    end else if (apply) begin
      pending_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_word <= '0;
      running  <= 1'b0;
    end else if (apply) begin
      act_word <= shadow_q;
      running  <= 1'b1;
    end
  end

  // R6: the active setting never moves while the pump is driving
  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pump_busy) |=> $stable(act_word));

  // R7: an illegal word is raised to the minimum and flagged
  p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_load && sf_word < sf_t'(SF_MIN)) |=> (clamped && shadow_q == sf_t'(SF_MIN)));

  // R7: the running setting is always within the legal range
  p_active_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (act_word >= sf_t'(SF_MIN)));
endmodule

// File: rtl/fnd_modsel.sv
module fnd_modsel
  import fnd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, frac};
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= sum[FRAC_W-1:0];
  end

  // R4: the phase is held between period boundaries
  p_acc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(acc_q));
endmodule

// File: rtl/fnd_count.sv
module fnd_count
  import fnd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic [CNT_W-1:0] reload,
  output logic             wrap,
  output logic [CNT_W-1:0] cnt
);
  assign wrap = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (start || wrap)     cnt <= reload;
    else if (run)               cnt <= cnt - 1'b1;
  end

  // R2: mid-period the counter steps down by one
  p_count_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R10: a terminal count is followed by a non-terminal one
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !wrap);
endmodule

// File: rtl/fnd_main_div.sv
module fnd_main_div
  import fnd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SF_W-1:0] sf_word,
  input  logic            sf_load,
  input  logic            pump_busy,
  input  logic            test_en,
  output logic            div_pulse,
  output logic            mon_out,
  output logic            sf_clamped
);
  logic             apply, running, wrap, carry, start;
  sf_t              eff_word, act_word;
  logic [CNT_W-1:0] cnt, reload;

  fnd_cfg_sync u_cfg (
    .clk(clk), .rst_n(rst_n), .sf_word(sf_word), .sf_load(sf_load),
    .pump_busy(pump_busy), .wrap(wrap), .apply(apply), .running(running),
    .eff_word(eff_word), .act_word(act_word), .clamped(sf_clamped)
  );

  assign start = apply && !running;

  fnd_modsel u_sel (
    .clk(clk), .rst_n(rst_n), .step(start || wrap),
    .frac(eff_word[FRAC_W-1:0]), .carry(carry)
  );

  assign reload = {1'b0, eff_word[SF_W-1:FRAC_W]} + CNT_W'(carry) - 1'b1;

  fnd_count u_cnt (
    .clk(clk), .rst_n(rst_n), .run(running), .start(start),
    .reload(reload), .wrap(wrap), .cnt(cnt)
  );

  assign div_pulse = wrap;
  assign mon_out   = test_en & wrap;

  // R2: every reload lands on N-1 or N for the setting now active
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == {1'b0, act_word[SF_W-1:FRAC_W]} - 1'b1 ||
              cnt == {1'b0, act_word[SF_W-1:FRAC_W]}));

  // R1: nothing comes out before the first setting is active
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !div_pulse);
endmodule

// File: tb/fnd_main_div_bench.sv
`timescale 1ns/1ps
module fnd_main_div_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [14:0] sf_word = '0;
  logic sf_load = 1'b0, pump_busy = 1'b0, test_en = 1'b0;
  logic div_pulse, mon_out, sf_clamped;

  always #2 clk = ~clk;

  fnd_main_div u_fnd_main_div (
    .clk(clk), .rst_n(rst_n), .sf_word(sf_word), .sf_load(sf_load),
    .pump_busy(pump_busy), .test_en(test_en), .div_pulse(div_pulse),
    .mon_out(mon_out), .sf_clamped(sf_clamped)
  );

  int checks = 0, errors = 0;
  int cyc = 0, last = 0, wr = 0, pulses = 0, dbl = 0, mon_bad = 0, mon_seen = 0;
  int base = 0;
  bit have_last = 0, prev_p = 0, done = 0;
  int ivs [0:511];

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (div_pulse) begin
      if (prev_p) dbl++;
      pulses++;
      if (have_last) begin ivs[wr % 512] = cyc - last; wr++; end
      last = cyc; have_last = 1;
    end
    prev_p = div_pulse;
    if (test_en ? (mon_out !== div_pulse) : (mon_out !== 1'b0)) mon_bad++;
    if (test_en && mon_out) mon_seen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic collect(input int n);
    int b = wr;
    while (wr < b + n) @(negedge clk);
    base = b;
  endtask

  function automatic int iv(input int i);
    return ivs[(base + i) % 512];
  endfunction

  task automatic load(input int w);
    @(posedge clk); #1 sf_word = 15'(w); sf_load = 1'b1;
    @(posedge clk); #1 sf_load = 1'b0;
  endtask

  task automatic check_ratio(input int n, input int k, input string tag);
    collect(2);
    collect(8);
    for (int i = 0; i < 8; i++)
      chk(iv(i) == n || iv(i) == n + 1, "R2", iv(i), n);
    for (int i = 0; i < 5; i++) begin
      int s = iv(i) + iv(i+1) + iv(i+2) + iv(i+3);
      chk(s == 4*n + k, tag, s, 4*n + k);
    end
  endtask

  task automatic t_reset_idle();
    chk(div_pulse == 1'b0, "R1", div_pulse, 0);
    chk(sf_clamped == 1'b0, "R1", sf_clamped, 0);
    repeat (3000) @(negedge clk);
    chk(pulses == 0, "R1", pulses, 0);
  endtask

  task automatic t_integer();
    load(2400);
    collect(2);
    collect(6);
    for (int i = 0; i < 6; i++) chk(iv(i) == 600, "R3", iv(i), 600);
  endtask

  task automatic t_no_strobe();
    @(posedge clk); #1 sf_word = 15'd4000;
    collect(3);
    for (int i = 0; i < 3; i++) chk(iv(i) == 600, "R5", iv(i), 600);
  endtask

  task automatic t_busy_hold();
    @(posedge clk); #1 pump_busy = 1'b1;
    load(2800);
    collect(3);
    for (int i = 0; i < 3; i++) chk(iv(i) == 600, "R6", iv(i), 600);
    repeat (10) @(posedge clk);
    #1 pump_busy = 1'b0;
    collect(3);
    chk(iv(0) == 600, "R6", iv(0), 600);
    chk(iv(1) == 700, "R6", iv(1), 700);
    chk(iv(2) == 700, "R6", iv(2), 700);
  endtask

  task automatic t_fraction();
    for (int k = 1; k < 4; k++) begin
      load(4*520 + k);
      check_ratio(520, k, "R4");
    end
  endtask

  task automatic t_clamp();
    load(100);
    chk(sf_clamped == 1'b1, "R7", sf_clamped, 1);
    collect(2);
    collect(4);
    for (int i = 0; i < 4; i++) chk(iv(i) == 512, "R7", iv(i), 512);
    load(2400);
    chk(sf_clamped == 1'b0, "R7", sf_clamped, 0);
  endtask

  task automatic t_monitor();
    collect(2);
    @(posedge clk); #1 test_en = 1'b1;
    collect(3);
    @(posedge clk); #1 test_en = 1'b0;
    collect(2);
    chk(mon_bad == 0, "R8", mon_bad, 0);
    chk(mon_seen >= 3, "R8", mon_seen, 3);
  endtask

  task automatic t_max();
    load(32767);
    collect(2);
    collect(4);
    for (int i = 0; i < 4; i++)
      chk(iv(i) == 8191 || iv(i) == 8192, "R9", iv(i), 8191);
    chk(iv(0) + iv(1) + iv(2) + iv(3) == 32767, "R9",
        iv(0) + iv(1) + iv(2) + iv(3), 32767);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_idle();
    t_integer();
    t_no_strobe();
    t_busy_hold();
    t_fraction();
    t_clamp();
    t_monitor();
    t_max();
    chk(dbl == 0, "R10", dbl, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 180000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule